// File: doc/BRIEF.md
# Dual-Domain Sample Timestamp Counter

This block keeps a running sample count for the receive path and another for the transmit path. Each path has its own sample clock, and each count advances once for every sample strobe seen in that clock. Software on a control bus in a third clock reads either count as two data words. A read of the low word takes a snapshot of the whole count inside the sample domain. The upper half of that same snapshot is then held for the later high-word read, so a carry between the two accesses cannot produce a torn value.

A single control-domain enable starts both counts. It is registered and then resynchronised into each sample clock. While the enable is low, each count holds its value. When the enable rises again, both counts restart from zero together, and they may differ by at most one sample clock of synchroniser skew.

Reads travel over a valid/ready request channel and come back over a valid/ready response channel. Only one request is accepted at a time. A low-word read stalls until the snapshot handshake returns from the sample domain. A high-word read answers from the control-side copy without crossing clocks. The response sits on the port, unchanged, until the consumer takes it.

Top module: `sample_stamp_unit`

## Requirements
- R1: Each direction counts its own sample strobes (`rx_smp_vld` in `rx_clk`, `tx_smp_vld` in `tx_clk`). Its count rises by exactly one per strobe while enabled and never moves by any other step except a clear to zero. The two directions are independent.
- R2: Each count is 2*WORD_W bits wide and is read as two words. `req_addr[2]`=0 selects the low word and 1 selects the high word. `req_addr[3]`=0 selects receive and 1 selects transmit. `req_addr[1:0]` is ignored.
- R3: A low-word read captures the full count of the chosen direction. The next high-word read of that direction returns the upper half of that capture, even if the live count has since crossed into the upper half.
- R4: While the synchronised enable is low, strobes are ignored and the count holds. Reads return the held value.
- R5: A rise of `stamp_en` restarts both counts from zero.
- R6: Driving `rx_rst_n` or `tx_rst_n` low clears only that direction's count.
- R7: `req_ready` is high only when no request is in flight. After a request is accepted, `req_ready` stays low until its response has been taken.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high and `rsp_data` stays stable.
- R9: After control reset, `req_ready` is 1 and `rsp_valid` is 0. Every count and every captured value is 0, so a read returns 0.
- R10: A high-word read raises `rsp_valid` in the cycle after the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Control bus clock |
| ctl_rst_n | input | 1 | Control-domain reset, active low |
| stamp_en | input | 1 | Count enable, control domain |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read request ready |
| req_addr | input | 4 | Bit 3: direction, bit 2: word half |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Read data accepted |
| rsp_data | output | WORD_W | Read data word |
| rx_clk | input | 1 | Receive sample clock |
| rx_rst_n | input | 1 | Receive datapath reset, active low |
| rx_smp_vld | input | 1 | Receive sample strobe |
| tx_clk | input | 1 | Transmit sample clock |
| tx_rst_n | input | 1 | Transmit datapath reset, active low |
| tx_smp_vld | input | 1 | Transmit sample strobe |

## Verification
The checks assume that `req_addr` stays stable while `req_valid` is high and unaccepted. They also assume that `stamp_en` stays at one level for many more control cycles than the synchroniser depth. The stimulus changes the enable only with idle margins of thirty control cycles, and it sends strobes only after that settling time. It releases a datapath reset only while no strobe is being sent. To exercise the carry case within a short run, the bench shrinks the word width to eight bits. It throttles `rsp_ready` in a phase of its own to test back-pressure.

// File: rtl/stamp_pkg.sv
package stamp_pkg;
  localparam int DIR_N  = 2;
  localparam int DIR_RX = 0;
  localparam int DIR_TX = 1;

  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_WAIT = 2'd1,
    CS_RESP = 2'd2
  } ctl_state_t;
endpackage

// File: rtl/stamp_sync.sv
module stamp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/stamp_counter.sv
module stamp_counter #(
  parameter int CNT_W  = 64,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_vld,
  input  logic             en_async,
  input  logic             req_async,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] snap_o,
  output logic             run_o,
  output logic             en_s_o,
  output logic             ack_o
);
  logic             en_s, req_s, run_q, ack_q;
  logic [CNT_W-1:0] cnt_q, snap_q;

  stamp_sync #(.STAGES(SYNC_N)) u_en_sync (
    .clk(clk), .rst_n(rst_n), .d(en_async), .q(en_s)
  );
  stamp_sync #(.STAGES(SYNC_N)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d(req_async), .q(req_s)
  );

  // restart at the enable rise; count strobes once running
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= en_s;
      if (en_s && !run_q)
        cnt_q <= '0;
      else if (run_q && smp_vld)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  // snapshot on request toggle mismatch, then echo the toggle back
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      ack_q  <= 1'b0;
    end else if (req_s != ack_q) begin
      snap_q <= cnt_q;
      ack_q  <= req_s;
    end
  end

  assign cnt_o  = cnt_q;
  assign snap_o = snap_q;
  assign run_o  = run_q;
  assign en_s_o = en_s;
  assign ack_o  = ack_q;
endmodule

// File: rtl/stamp_ctl.sv
module stamp_ctl
  import stamp_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int SYNC_N = 2,
  localparam int CNT_W = 2 * WORD_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        addr_hi,
  input  logic                        addr_dir,
  output logic                        rsp_valid,
  input  logic                        rsp_ready,
  output logic [WORD_W-1:0]           rsp_data,
  input  logic [DIR_N-1:0][CNT_W-1:0] snap_i,
  input  logic [DIR_N-1:0]            ack_i,
  output logic [DIR_N-1:0]            req_tog_o
);
  ctl_state_t                  st_q;
  logic                        sel_q;
  logic [DIR_N-1:0]            tog_q, ack_s;
  logic [DIR_N-1:0][CNT_W-1:0] hold_q;
  logic [WORD_W-1:0]           data_q;

  for (genvar d = 0; d < DIR_N; d++) begin : g_ack
    stamp_sync #(.STAGES(SYNC_N)) u_ack_sync (
      .clk(clk), .rst_n(rst_n), .d(ack_i[d]), .q(ack_s[d])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CS_IDLE;
      sel_q  <= 1'b0;
      tog_q  <= '0;
      hold_q <= '0;
      data_q <= '0;
    end else begin
      unique case (st_q)
        CS_IDLE: if (req_valid) begin
          sel_q <= addr_dir;
          if (addr_hi) begin
            data_q <= hold_q[addr_dir][CNT_W-1:WORD_W];
            st_q   <= CS_RESP;
          end else begin
            tog_q[addr_dir] <= ~tog_q[addr_dir];
            st_q            <= CS_WAIT;
          end
        end
        CS_WAIT: if (ack_s[sel_q] == tog_q[sel_q]) begin
          hold_q[sel_q] <= snap_i[sel_q];
          data_q        <= snap_i[sel_q][WORD_W-1:0];
          st_q          <= CS_RESP;
        end
        CS_RESP: if (rsp_ready) st_q <= CS_IDLE;
        default: st_q <= CS_IDLE;
      endcase
    end
  end

  assign req_ready = (st_q == CS_IDLE);
  assign rsp_valid = (st_q == CS_RESP);
  assign rsp_data  = data_q;
  assign req_tog_o = tog_q;
endmodule

// File: rtl/sample_stamp_unit.sv
module sample_stamp_unit
  import stamp_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int SYNC_N = 2
) (
  input  logic              ctl_clk,
  input  logic              ctl_rst_n,
  input  logic              stamp_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_data,
  input  logic              rx_clk,
  input  logic              rx_rst_n,
  input  logic              rx_smp_vld,
  input  logic              tx_clk,
  input  logic              tx_rst_n,
  input  logic              tx_smp_vld
);
  localparam int CNT_W = 2 * WORD_W;

  logic                        en_q;
  logic [DIR_N-1:0]            smp_clk, smp_rst_n, smp_vld;
  logic [DIR_N-1:0][CNT_W-1:0] cnt_w, snap_w;
  logic [DIR_N-1:0]            run_w, en_s_w, ack_w, req_tog_w;
  logic                        unused_addr_bits;

  assign unused_addr_bits = ^req_addr[1:0];

  always_ff @(posedge ctl_clk or negedge ctl_rst_n) begin
    if (!ctl_rst_n) en_q <= 1'b0;
    else            en_q <= stamp_en;
  end

  assign smp_clk[DIR_RX]   = rx_clk;
  assign smp_clk[DIR_TX]   = tx_clk;
  assign smp_rst_n[DIR_RX] = rx_rst_n;
  assign smp_rst_n[DIR_TX] = tx_rst_n;
  assign smp_vld[DIR_RX]   = rx_smp_vld;
  assign smp_vld[DIR_TX]   = tx_smp_vld;

  for (genvar d = 0; d < DIR_N; d++) begin : g_dir
    stamp_counter #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_cnt (
      .clk      (smp_clk[d]),
      .rst_n    (smp_rst_n[d]),
      .smp_vld  (smp_vld[d]),
      .en_async (en_q),
      .req_async(req_tog_w[d]),
      .cnt_o    (cnt_w[d]),
      .snap_o   (snap_w[d]),
      .run_o    (run_w[d]),
      .en_s_o   (en_s_w[d]),
      .ack_o    (ack_w[d])
    );
  end

  stamp_ctl #(.WORD_W(WORD_W), .SYNC_N(SYNC_N)) u_ctl (
    .clk      (ctl_clk),
    .rst_n    (ctl_rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .addr_hi  (req_addr[2]),
    .addr_dir (req_addr[3]),
    .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready),
    .rsp_data (rsp_data),
    .snap_i   (snap_w),
    .ack_i    (ack_w),
    .req_tog_o(req_tog_w)
  );
endmodule

// File: rtl/stamp_checker.sv
module stamp_checker #(
  parameter int WORD_W = 32,
  localparam int CNT_W = 2 * WORD_W
) (
  input logic                  ctl_clk,
  input logic                  ctl_rst_n,
  input logic                  rx_clk,
  input logic                  rx_rst_n,
  input logic                  tx_clk,
  input logic                  tx_rst_n,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic [3:0]            req_addr,
  input logic                  rsp_valid,
  input logic                  rsp_ready,
  input logic [WORD_W-1:0]     rsp_data,
  input logic [1:0][CNT_W-1:0] cnt_w,
  input logic [1:0][CNT_W-1:0] snap_w,
  input logic [1:0]            run_w,
  input logic [1:0]            en_s_w,
  input logic [1:0]            ack_w
);
  p_busy_blocks_r7: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
    rsp_valid |-> !req_ready);
  p_accept_busy_r7: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
    (req_valid && req_ready) |=> !req_ready);
  p_rsp_hold_r8: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  p_hi_fast_r10: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
    (req_valid && req_ready && req_addr[2]) |=> rsp_valid);

  p_rx_step_r1: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    !$stable(cnt_w[0]) |-> (cnt_w[0] == CNT_W'($past(cnt_w[0]) + 1'b1) || cnt_w[0] == '0));
  p_tx_step_r1: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    !$stable(cnt_w[1]) |-> (cnt_w[1] == CNT_W'($past(cnt_w[1]) + 1'b1) || cnt_w[1] == '0));
  p_rx_hold_r4: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    (!en_s_w[0] && !run_w[0]) |=> $stable(cnt_w[0]));
  p_tx_hold_r4: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    (!en_s_w[1] && !run_w[1]) |=> $stable(cnt_w[1]));
  p_rx_snap_r3: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    $stable(ack_w[0]) |-> $stable(snap_w[0]));
  p_tx_snap_r3: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    $stable(ack_w[1]) |-> $stable(snap_w[1]));
endmodule

bind sample_stamp_unit stamp_checker #(.WORD_W(WORD_W)) u_stamp_chk (
  .ctl_clk  (ctl_clk),
  .ctl_rst_n(ctl_rst_n),
  .rx_clk   (rx_clk),
  .rx_rst_n (rx_rst_n),
  .tx_clk   (tx_clk),
  .tx_rst_n (tx_rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_addr (req_addr),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_data (rsp_data),
  .cnt_w    (cnt_w),
  .snap_w   (snap_w),
  .run_w    (run_w),
  .en_s_w   (en_s_w),
  .ack_w    (ack_w)
);

// File: tb/sim_sample_stamp_unit.sv
module sim_sample_stamp_unit;
  localparam int WW = 8;

  logic ctl_clk = 0, rx_clk = 0, tx_clk = 0;
  logic ctl_rst_n = 0, rx_rst_n = 0, tx_rst_n = 0;
  logic stamp_en = 0, req_valid = 0, rsp_ready = 1;
  logic rx_smp_vld = 0, tx_smp_vld = 0;
  logic [3:0] req_addr = '0;
  logic req_ready, rsp_valid;
  logic [WW-1:0] rsp_data;
  logic stall_mode = 0;

  int checks = 0, fails = 0;
  logic [WW-1:0] exp_q[$];
  string         tag_q[$];

  always #2.5 ctl_clk = ~ctl_clk;
  always #3.5 rx_clk  = ~rx_clk;
  always #5.5 tx_clk  = ~tx_clk;

  sample_stamp_unit #(.WORD_W(WW)) u0 (
    .ctl_clk(ctl_clk), .ctl_rst_n(ctl_rst_n), .stamp_en(stamp_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rx_clk(rx_clk), .rx_rst_n(rx_rst_n), .rx_smp_vld(rx_smp_vld),
    .tx_clk(tx_clk), .tx_rst_n(tx_rst_n), .tx_smp_vld(tx_smp_vld)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge ctl_clk) rsp_ready <= stall_mode ? ~rsp_ready : 1'b1;

  // monitor: pop and compare each consumed response
  always @(negedge ctl_clk) begin
    if (ctl_rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) check("R7 unexpected response", 1, 0);
      else begin
        string t;
        logic [WW-1:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, int'(rsp_data), int'(e));
      end
    end
  end

  // driver: push expected value, issue request
  task automatic rd(input logic [3:0] addr, input logic [WW-1:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge ctl_clk);
    req_valid = 1;
    req_addr  = addr;
    while (!req_ready) @(negedge ctl_clk);
    @(negedge ctl_clk);
    req_valid = 0;
    check("R7 ready low after accept", int'(req_ready), 0);
    if (addr[2]) check("R10 high word next cycle", int'(rsp_valid), 1);
    while (exp_q.size() != 0) @(negedge ctl_clk);
  endtask

  task automatic rx_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge rx_clk) rx_smp_vld = 1;
    end
    @(negedge rx_clk) rx_smp_vld = 0;
  endtask

  task automatic tx_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge tx_clk) tx_smp_vld = 1;
    end
    @(negedge tx_clk) tx_smp_vld = 0;
  endtask

  task automatic settle();
    repeat (30) @(negedge ctl_clk);
  endtask

  initial begin
    repeat (150000) @(posedge ctl_clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge ctl_clk);
    ctl_rst_n = 1; rx_rst_n = 1; tx_rst_n = 1;
    @(negedge ctl_clk);
    check("R9 req_ready after reset", int'(req_ready), 1);
    check("R9 rsp_valid after reset", int'(rsp_valid), 0);
    rd(4'hC, 0, "R9 tx high before any capture");

    rx_pulses(5);
    settle();
    rd(4'h0, 0, "R4 rx low disabled");
    rd(4'h4, 0, "R4 rx high disabled");

    stamp_en = 1; settle();
    fork rx_pulses(100); tx_pulses(37); join
    settle();
    rd(4'h0, 100, "R1 rx low");
    rd(4'h4, 0,   "R2 rx high");
    rd(4'h8, 37,  "R1 tx low");
    rd(4'hF, 0,   "R2 tx high, low addr bits ignored");

    rx_pulses(150);
    settle();
    rd(4'h0, 250, "R3 rx low capture");
    rx_pulses(10);
    settle();
    rd(4'h4, 0,   "R3 rx high from capture");
    rd(4'h0, 4,   "R2 rx low after carry");
    rd(4'h4, 1,   "R2 rx high after carry");

    stall_mode = 1;
    rd(4'h8, 37, "R8 tx low under back-pressure");
    rd(4'hC, 0,  "R8 tx high under back-pressure");
    stall_mode = 0;

    stamp_en = 0; settle();
    tx_pulses(9); settle();
    rd(4'h8, 37, "R4 tx held while disabled");

    stamp_en = 1; settle();
    rd(4'h0, 0, "R5 rx restarts");
    rd(4'h8, 0, "R5 tx restarts");
    fork rx_pulses(3); tx_pulses(2); join
    settle();
    rd(4'h0, 3, "R1 rx after restart");
    rd(4'h8, 2, "R1 tx after restart");

    tx_pulses(4);
    @(negedge rx_clk) rx_rst_n = 0;
    repeat (3) @(negedge rx_clk);
    rx_rst_n = 1;
    settle();
    rd(4'h0, 0, "R6 rx cleared by its reset");
    rd(4'h8, 6, "R6 tx untouched by rx reset");

    settle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule